// File: doc/BRIEF.md
# Instruction Breakpoint and Step Counter

This block decides, for every instruction that is about to retire, whether a debug trap must be taken instead. It has two sources of traps. The first is a bank of instruction-address comparators, each armed by one bit of an enable register. The second is an instruction step counter. The counter advances once for each counted instruction and traps when its next increment would wrap to zero. The pipeline presents the fetch PC, the current interrupt level and the configured debug level, together with a valid strobe. In that same cycle the block returns at most one trap pulse. The exception entry, the flush and the decode are handled elsewhere.

Software programs the block through a single-cycle special-register port. A write takes effect at the next clock edge. A read returns the addressed register combinationally. Two separate gates apply. The address triggers, and the trap raised by the counter, are enabled only while the interrupt level is strictly below the debug level. Counting itself is enabled only while the interrupt level is strictly below the 4-bit count-level register.

The per-instruction outcome is an enumerated decision with four values:
- IDLE: no instruction is presented.
- RETIRE: the instruction proceeds with no trap.
- STEP_TRAP: the counter trap fires.
- ADDR_TRAP: an address breakpoint fires.

The decision is evaluated in priority order: IDLE first, then STEP_TRAP, then ADDR_TRAP, and RETIRE otherwise.

Top module: `dbg_trig_unit`

## Requirements
- R1: The register at index 0 holds the breakpoint arm mask, with bit i arming breakpoint i. A write keeps only the bits below NUM_BP (2), and the register reads 0 after reset.
- R2: Breakpoint i sits at index 3+i. When `insn_valid` is high, debug is open, breakpoint i is armed and its address equals `insn_pc`, the block raises `trig_addr` and reports i on `trig_bp_id`.
- R3: When several armed breakpoints match, `trig_bp_id` reports the lowest index among them.
- R4: Neither trigger fires unless `cur_level` is strictly below `dbg_level`.
- R5: The count-level register is at index 2 and keeps only bits 3:0 of a write. The counter at index 1 changes on a valid instruction only when `cur_level` is strictly below the count level.
- R6: For a counted instruction, if count+1 is nonzero, the counter holds count+1 after the clock edge.
- R7: For a counted instruction, if count+1 wraps to zero, the counter keeps its value. In that case `trig_step` pulses when debug is open, and stays low otherwise.
- R8: When the step trap and an address match occur on the same instruction, only `trig_step` fires.
- R9: A software write to the counter in the same cycle as a counted instruction sets the counter to the written value.
- R10: All registers read 0 after reset. Indices outside the map read 0, and writes to them change no register.
- R11: The trigger outputs are high only in a cycle where `insn_valid` is high, and they last only for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_we | input | 1 | Special-register write strobe |
| sr_idx | input | 4 | Special-register index |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data for `sr_idx` (combinational) |
| insn_valid | input | 1 | An instruction is about to retire |
| insn_pc | input | 32 | PC of that instruction |
| cur_level | input | 4 | Current interrupt level |
| dbg_level | input | 4 | Configured debug level |
| trig_step | output | 1 | Step-counter trap pulse |
| trig_addr | output | 1 | Address-breakpoint trap pulse |
| trig_bp_id | output | 1 | Index of the breakpoint that fired |

## Verification
The address match is tried with the following patterns:
- the armed address, which must fire;
- a neighbouring PC, which must not fire;
- the armed address after disarming, which must not fire;
- both comparators set to the same PC under different arm masks, which separates the correct priority order from a reversed one.

The gates are probed with the interrupt level equal to the threshold and one below it. This exposes a comparison written as "not greater" where it should be "strictly less".

The counter is driven through three cases: a plain increment, the value one step before wrap, and the all-ones value. The all-ones case is tried with debug open and with debug closed, which distinguishes "hold" from "wrap" and "trap" from "silent".

Finally, a wrap and an address match are put on the same PC, and a software write is placed on a counted cycle. These two cases resolve the order in which the decisions are taken.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int XLEN  = 32;
    localparam int LVL_W = 4;
    localparam int IDX_W = 4;

    // special-register map; breakpoint addresses follow contiguously
    localparam int SR_BP_EN    = 0;
    localparam int SR_STEP_CNT = 1;
    localparam int SR_STEP_LVL = 2;
    localparam int SR_BP_ADDR0 = 3;

    typedef enum logic [1:0] {
        OUT_IDLE      = 2'd0,
        OUT_RETIRE    = 2'd1,
        OUT_STEP_TRAP = 2'd2,
        OUT_ADDR_TRAP = 2'd3
    } outcome_e;

endpackage

// File: rtl/dbg_bp_bank.sv
module dbg_bp_bank
    import dbg_trig_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int AW     = XLEN,
    parameter int IW     = IDX_W,
    parameter int BPID_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IW-1:0]                wr_idx,
    input  logic [AW-1:0]                wr_data,
    input  logic [AW-1:0]                pc,
    output logic [NUM_BP-1:0]            arm_q,
    output logic [NUM_BP-1:0][AW-1:0]    addr_q,
    output logic                         hit,
    output logic [BPID_W-1:0]            hit_id
);

    localparam logic [IW-1:0] EN_IDX = IW'(SR_BP_EN);

    logic [NUM_BP-1:0] match;
    logic              arm_wr;

    assign arm_wr = wr_en && (wr_idx == EN_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else if (arm_wr) begin
            arm_q <= wr_data[NUM_BP-1:0];
        end
    end

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        localparam logic [IW-1:0] MY_IDX = IW'(SR_BP_ADDR0 + g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
            end else if (wr_en && (wr_idx == MY_IDX)) begin
                addr_q[g] <= wr_data;
            end
        end

        assign match[g] = arm_q[g] && (addr_q[g] == pc);
    end

    // lowest index wins: scan downward so the last assignment is the smallest
    always_comb begin
        hit_id = '0;
        for (int i = NUM_BP - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_id = BPID_W'(i);
            end
        end
    end

    assign hit = |match;

    // R1
    arm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> arm_q == $past(wr_data[NUM_BP-1:0]));

    // R2
    hit_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (arm_q[hit_id] && addr_q[hit_id] == pc));

endmodule

// File: rtl/dbg_step_ctr.sv
module dbg_step_ctr
    import dbg_trig_pkg::*;
#(
    parameter int CW = XLEN,
    parameter int LW = LVL_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_data,
    input  logic          insn_valid,
    input  logic [LW-1:0] cur_level,
    output logic [CW-1:0] cnt_q,
    output logic [LW-1:0] lvl_q,
    output logic          wrap
);

    localparam logic [IW-1:0] CNT_IDX = IW'(SR_STEP_CNT);
    localparam logic [IW-1:0] LVL_IDX = IW'(SR_STEP_LVL);

    logic          active;
    logic          cnt_wr;
    logic          lvl_wr;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] cnt_d;

    assign cnt_wr  = wr_en && (wr_idx == CNT_IDX);
    assign lvl_wr  = wr_en && (wr_idx == LVL_IDX);
    assign active  = insn_valid && (cur_level < lvl_q);
    assign cnt_inc = cnt_q + CW'(1);
    assign wrap    = active && (cnt_inc == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            cnt_d = wr_data;
        end else if (active && !wrap) begin
            cnt_d = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (lvl_wr) begin
                lvl_q <= wr_data[LW-1:0];
            end
        end
    end

    // R5
    lvl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr |=> lvl_q == $past(wr_data[LW-1:0]));

    // R7
    wrap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cnt_wr) |=> $stable(cnt_q));

    // R9
    sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wr_data));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_valid && !cnt_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int BPID_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_we,
    input  logic [IDX_W-1:0]  sr_idx,
    input  logic [XLEN-1:0]   sr_wdata,
    output logic [XLEN-1:0]   sr_rdata,
    input  logic              insn_valid,
    input  logic [XLEN-1:0]   insn_pc,
    input  logic [LVL_W-1:0]  cur_level,
    input  logic [LVL_W-1:0]  dbg_level,
    output logic              trig_step,
    output logic              trig_addr,
    output logic [BPID_W-1:0] trig_bp_id
);

    logic [NUM_BP-1:0]           arm_q;
    logic [NUM_BP-1:0][XLEN-1:0] addr_q;
    logic                        bp_hit;
    logic [BPID_W-1:0]           bp_id;
    logic [XLEN-1:0]             cnt_q;
    logic [LVL_W-1:0]            lvl_q;
    logic                        step_wrap;
    logic                        dbg_open;
    outcome_e                    outcome;

    dbg_bp_bank #(
        .NUM_BP (NUM_BP),
        .AW     (XLEN),
        .IW     (IDX_W),
        .BPID_W (BPID_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sr_we),
        .wr_idx  (sr_idx),
        .wr_data (sr_wdata),
        .pc      (insn_pc),
        .arm_q   (arm_q),
        .addr_q  (addr_q),
        .hit     (bp_hit),
        .hit_id  (bp_id)
    );

    dbg_step_ctr #(
        .CW (XLEN),
        .LW (LVL_W),
        .IW (IDX_W)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (sr_we),
        .wr_idx     (sr_idx),
        .wr_data    (sr_wdata),
        .insn_valid (insn_valid),
        .cur_level  (cur_level),
        .cnt_q      (cnt_q),
        .lvl_q      (lvl_q),
        .wrap       (step_wrap)
    );

    assign dbg_open = cur_level < dbg_level;

    // outcome decision: step trap is judged before the address compare
    always_comb begin
        if (!insn_valid) begin
            outcome = OUT_IDLE;
        end else if (step_wrap && dbg_open) begin
            outcome = OUT_STEP_TRAP;
        end else if (bp_hit && dbg_open) begin
            outcome = OUT_ADDR_TRAP;
        end else begin
            outcome = OUT_RETIRE;
        end
    end

    always_comb begin
        trig_step  = 1'b0;
        trig_addr  = 1'b0;
        trig_bp_id = '0;
        unique case (outcome)
            OUT_IDLE:      ;
            OUT_RETIRE:    ;
            OUT_STEP_TRAP: trig_step = 1'b1;
            OUT_ADDR_TRAP: begin
                trig_addr  = 1'b1;
                trig_bp_id = bp_id;
            end
        endcase
    end

    always_comb begin
        sr_rdata = '0;
        if (sr_idx == IDX_W'(SR_BP_EN)) begin
            sr_rdata[NUM_BP-1:0] = arm_q;
        end else if (sr_idx == IDX_W'(SR_STEP_CNT)) begin
            sr_rdata = cnt_q;
        end else if (sr_idx == IDX_W'(SR_STEP_LVL)) begin
            sr_rdata[LVL_W-1:0] = lvl_q;
        end
        for (int i = 0; i < NUM_BP; i++) begin
            if (sr_idx == IDX_W'(SR_BP_ADDR0 + i)) begin
                sr_rdata = addr_q[i];
            end
        end
    end

    // R8
    one_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_step && trig_addr));

    // R11
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_step || trig_addr) |-> insn_valid);

    // R4
    level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_step || trig_addr) |-> (cur_level < dbg_level));

    // R3
    low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_addr && arm_q[0] && addr_q[0] == insn_pc) |-> trig_bp_id == '0);

endmodule

// File: tb/sim_dbg_trig_unit.sv
module sim_dbg_trig_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_we = 1'b0;
    logic [3:0]  sr_idx = '0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_pc = '0;
    logic [3:0]  cur_level = '0;
    logic [3:0]  dbg_level = 4'd6;
    logic        trig_step;
    logic        trig_addr;
    logic [0:0]  trig_bp_id;

    int tests = 0;
    int fails = 0;

    dbg_trig_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_we      (sr_we),
        .sr_idx     (sr_idx),
        .sr_wdata   (sr_wdata),
        .sr_rdata   (sr_rdata),
        .insn_valid (insn_valid),
        .insn_pc    (insn_pc),
        .cur_level  (cur_level),
        .dbg_level  (dbg_level),
        .trig_step  (trig_step),
        .trig_addr  (trig_addr),
        .trig_bp_id (trig_bp_id)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sr_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        sr_we = 1'b1; sr_idx = 4'(idx); sr_wdata = d;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic sr_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        sr_idx = 4'(idx);
        #1 d = sr_rdata;
    endtask

    // present one instruction; returns {step, addr, id} sampled mid-cycle
    task automatic step(input logic [31:0] pc, input logic [3:0] lvl, output logic [2:0] r);
        @(negedge clk);
        insn_valid = 1'b1; insn_pc = pc; cur_level = lvl;
        #1 r = {trig_step, trig_addr, trig_bp_id};
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) begin
            sr_read(i, d);
            chk("R10 reset reg", d, 32'h0);
        end
        sr_read(0, d);
        chk("R1 arm mask reset", d, 32'h0);
    endtask

    task automatic t_arm_mask();
        logic [31:0] d;
        sr_write(0, 32'hFFFF_FFFF);
        sr_read(0, d);
        chk("R1 arm mask width", d, 32'h3);
        sr_write(0, 32'h0);
    endtask

    task automatic t_bp_match();
        logic [2:0] r;
        sr_write(3, 32'h0000_1000);
        sr_write(0, 32'h1);
        step(32'h1000, 4'd2, r);
        chk("R2 match fires", 32'(r), 32'b010);
        step(32'h1004, 4'd2, r);
        chk("R2 other pc quiet", 32'(r), 32'b000);
        @(negedge clk); insn_pc = 32'h1000;
        #1 chk("R11 no strobe no trig", {31'b0, trig_addr}, 32'h0);
        sr_write(0, 32'h0);
        step(32'h1000, 4'd2, r);
        chk("R1 disarmed quiet", 32'(r), 32'b000);
    endtask

    task automatic t_priority();
        logic [2:0] r;
        sr_write(3, 32'h2000);
        sr_write(4, 32'h2000);
        sr_write(0, 32'h3);
        step(32'h2000, 4'd0, r);
        chk("R3 lowest wins", 32'(r), 32'b010);
        #1 chk("R11 pulse ends", {31'b0, trig_addr}, 32'h0);
        sr_write(0, 32'h2);
        step(32'h2000, 4'd0, r);
        chk("R3 second only", 32'(r), 32'b011);
    endtask

    task automatic t_level_gate();
        logic [2:0] r;
        step(32'h2000, 4'd6, r);
        chk("R4 equal level quiet", 32'(r), 32'b000);
        step(32'h2000, 4'd5, r);
        chk("R4 below level fires", 32'(r), 32'b011);
        sr_write(0, 32'h0);
    endtask

    task automatic t_count_step();
        logic [2:0]  r;
        logic [31:0] d;
        sr_write(2, 32'h1);
        sr_write(1, 32'd5);
        for (int i = 0; i < 3; i++) step(32'h100, 4'd0, r);
        sr_read(1, d);
        chk("R6 count advances", d, 32'd8);
        step(32'h100, 4'd1, r);
        sr_read(1, d);
        chk("R5 level gate holds count", d, 32'd8);
        sr_write(2, 32'h1F);
        sr_read(2, d);
        chk("R5 level mask", d, 32'hF);
        sr_write(2, 32'h1);
    endtask

    task automatic t_count_wrap();
        logic [2:0]  r;
        logic [31:0] d;
        sr_write(1, 32'hFFFF_FFFE);
        step(32'h100, 4'd0, r);
        chk("R6 pre-wrap quiet", 32'(r), 32'b000);
        sr_read(1, d);
        chk("R6 reaches all-ones", d, 32'hFFFF_FFFF);
        step(32'h100, 4'd0, r);
        chk("R7 wrap trap", 32'(r), 32'b100);
        sr_read(1, d);
        chk("R7 wrap holds", d, 32'hFFFF_FFFF);
        dbg_level = 4'd0;
        step(32'h100, 4'd0, r);
        chk("R7 debug closed silent", 32'(r), 32'b000);
        sr_read(1, d);
        chk("R7 debug closed holds", d, 32'hFFFF_FFFF);
        dbg_level = 4'd6;
    endtask

    task automatic t_count_vs_bp();
        logic [2:0]  r;
        logic [31:0] d;
        sr_write(3, 32'h3000);
        sr_write(0, 32'h1);
        step(32'h3000, 4'd0, r);
        chk("R8 step beats addr", 32'(r), 32'b100);
        sr_write(1, 32'h0);
        step(32'h3000, 4'd0, r);
        chk("R8 addr after reload", 32'(r), 32'b010);
        sr_read(1, d);
        chk("R6 counted with addr", d, 32'h1);
        sr_write(0, 32'h0);
    endtask

    task automatic t_sw_override();
        logic [31:0] d;
        sr_write(1, 32'd10);
        @(negedge clk);
        insn_valid = 1'b1; insn_pc = 32'h500; cur_level = 4'd0;
        sr_we = 1'b1; sr_idx = 4'd1; sr_wdata = 32'd100;
        @(negedge clk);
        insn_valid = 1'b0; sr_we = 1'b0;
        sr_read(1, d);
        chk("R9 software write wins", d, 32'd100);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        sr_write(9, 32'hDEAD_BEEF);
        sr_read(9, d);
        chk("R10 unmapped reads zero", d, 32'h0);
        sr_read(1, d);
        chk("R10 count untouched", d, 32'd100);
        sr_read(3, d);
        chk("R10 addr untouched", d, 32'h3000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_arm_mask();
        t_bp_match();
        t_priority();
        t_level_gate();
        t_count_step();
        t_count_wrap();
        t_count_vs_bp();
        t_sw_override();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R11 watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule